// File: doc/BRIEF.md
# Address-Holding One-of-N Decoder

This block turns a small binary address into a set of active-low select lines, exactly one of which goes low for the selected index. An address hold stage sits in front of the decoder: while the hold control is low the live address passes straight through, and once hold goes high the last address seen is kept and further address changes are ignored. This lets a bus master present an address briefly, freeze it, and move on to other traffic.

A pair of enables with opposite polarity gates the outputs. Either enable can force every select line high without disturbing the held address, so an address can be stored now and strobed onto the outputs later. The address width is a parameter and the output count follows from it. Several instances can therefore be cascaded, with upper address bits driving the enables of lower instances, to build wider decoders.

The hold stage has two variants. The default clocked variant samples the hold control on the clock and needs no level-sensitive storage. The transparent-latch variant is chosen by a parameter.

Top module: `addr_latch_decoder`

## Requirements
- R1: While `hold` is low and the outputs are enabled, `sel_n` follows the live `addr` with no clock delay. Exactly bit `addr` of `sel_n` is low, with `addr[0]` the least significant bit, so `addr` = 3'b101 drives `sel_n[5]` low.
- R2: In the clocked variant the stored address is the value of `addr` at the last rising clock edge at which `hold` was low. While `hold` is high, the enabled outputs decode that stored address.
- R3: While `hold` stays high, changes on `addr` have no effect on `sel_n`.
- R4: When `hold` returns low, the live `addr` reaches `sel_n` at once, in the same cycle.
- R5: All bits of `sel_n` are high unless `en_lo_n` is low and `en_hi` is high. This holds for every address and every hold state.
- R6: Disabling and then re-enabling the outputs leaves the stored address unchanged.
- R7: At most one bit of `sel_n` is low at any time, and exactly one is low whenever the outputs are enabled.
- R8: While `rst_n` is low the stored address is cleared to 0. After reset, with `hold` high and the outputs enabled, `sel_n[0]` is the low bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the clocked hold variant |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored address |
| hold | input | 1 | High freezes the address; low lets it pass through |
| addr | input | ADDR_W | Binary address, bit 0 least significant |
| en_lo_n | input | 1 | Active-low output enable |
| en_hi | input | 1 | Active-high output enable |
| sel_n | output | 2**ADDR_W | Active-low one-of-N select lines |

## Verification
On every clock the assertions check four things: the output is never more than one low bit, the outputs are all high when disabled, a pass-through decode matches the live address, and a freshly captured address stays on the outputs while hold remains high. Some behaviours only the bench's scenarios can show. These are the reset value of the store, the survival of a held address across a disable and re-enable, the immediate return to the live address when hold reopens, and the full sweep of addresses and enable combinations against independently computed patterns.

// File: rtl/lad_pkg.sv
package lad_pkg;

   typedef enum bit {
      HOLD_LATCH   = 1'b0,
      HOLD_CLOCKED = 1'b1
   } hold_mode_e;

   localparam int unsigned LAD_MAX_ADDR_W = 6;

endpackage

// File: rtl/lad_addr_hold.sv
module lad_addr_hold
   import lad_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter hold_mode_e  MODE   = HOLD_CLOCKED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] eff_addr
);

   logic [ADDR_W-1:0] kept_q;

   generate
      if (MODE == HOLD_CLOCKED) begin : g_clocked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               kept_q <= '0;
            else if (!hold)
               kept_q <= addr;
         end
      end else begin : g_latch
         always_latch begin
            if (!rst_n)
               kept_q = '0;
            else if (!hold)
               kept_q = addr;
         end
      end
   endgenerate

   // open: live address flows through; closed: stored value
   assign eff_addr = hold ? kept_q : addr;

endmodule

// File: rtl/lad_onehot.sv
module lad_onehot #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned N_OUT = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] code,
   output logic [N_OUT-1:0]  hot
);

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_line
         assign hot[i] = (code == ADDR_W'(i));
      end
   endgenerate

endmodule

// File: rtl/lad_out_gate.sv
module lad_out_gate #(
   parameter int unsigned N_OUT = 8
) (
   input  logic             en_lo_n,
   input  logic             en_hi,
   input  logic [N_OUT-1:0] hot,
   output logic [N_OUT-1:0] sel_n
);

   logic active;

   assign active = en_hi & ~en_lo_n;
   assign sel_n  = active ? ~hot : {N_OUT{1'b1}};

endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
   import lad_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter hold_mode_e  MODE   = HOLD_CLOCKED,
   localparam int unsigned N_OUT = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_lo_n,
   input  logic              en_hi,
   output logic [N_OUT-1:0]  sel_n
);

   generate
      if (ADDR_W < 1 || ADDR_W > LAD_MAX_ADDR_W) begin : g_bad_width
         $error("addr_latch_decoder: ADDR_W out of supported range");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic [N_OUT-1:0]  hot;

   lad_addr_hold #(
      .ADDR_W (ADDR_W),
      .MODE   (MODE)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .addr     (addr),
      .eff_addr (eff_addr)
   );

   lad_onehot #(
      .ADDR_W (ADDR_W)
   ) u_dec (
      .code (eff_addr),
      .hot  (hot)
   );

   lad_out_gate #(
      .N_OUT (N_OUT)
   ) u_gate (
      .en_lo_n (en_lo_n),
      .en_hi   (en_hi),
      .hot     (hot),
      .sel_n   (sel_n)
   );

endmodule

// File: rtl/lad_checker.sv
module lad_checker
   import lad_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter hold_mode_e  MODE   = HOLD_CLOCKED,
   localparam int unsigned N_OUT = 1 << ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold,
   input logic [ADDR_W-1:0] addr,
   input logic              en_lo_n,
   input logic              en_hi,
   input logic [N_OUT-1:0]  sel_n
);

   logic on;
   assign on = en_hi & ~en_lo_n;

   // R7: never more than one select low
   p_one_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sel_n) <= 1);

   // R5: disabled means all high
   p_disabled_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !on |-> (&sel_n));

   // R1: open hold decodes the live address
   p_open_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && on) |-> (sel_n == ~(N_OUT'(1) << addr)));

   generate
      if (MODE == HOLD_CLOCKED) begin : g_clk_props
         // R2: first closed cycle shows the address from the last open edge
         p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!hold) && hold && on) |-> (sel_n == ~(N_OUT'(1) << $past(addr))));

         // R3: address moves are invisible while hold stays high
         p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(hold) && hold && on && $past(on)) |-> $stable(sel_n));
      end
   endgenerate

endmodule

bind addr_latch_decoder lad_checker #(
   .ADDR_W (ADDR_W),
   .MODE   (MODE)
) u_chk (.*);

// File: tb/sim_addr_latch_decoder.sv
`timescale 1ns/1ps
module sim_addr_latch_decoder;
   import lad_pkg::*;

   localparam int AW = 3;
   localparam int NO = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hold = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          en_lo_n = 1'b1;
   logic          en_hi = 1'b0;
   logic [NO-1:0] sel_n;

   always #2 clk = ~clk; // 250 MHz

   addr_latch_decoder #(.ADDR_W(AW), .MODE(HOLD_CLOCKED)) u0 (
      .clk(clk), .rst_n(rst_n), .hold(hold), .addr(addr),
      .en_lo_n(en_lo_n), .en_hi(en_hi), .sel_n(sel_n)
   );

   typedef struct {
      logic [NO-1:0] exp;
      string         req;
   } item_t;

   item_t   sb[$];
   event    drv_ev;
   int      n_run = 0;
   int      n_fail = 0;
   logic [AW-1:0] model_store = '0;
   bit      finished = 0;

   function automatic logic [NO-1:0] pattern(logic [AW-1:0] a, logic lo_n, logic hi);
      if (!lo_n && hi) return ~(NO'(1) << a);
      return '1;
   endfunction

   task automatic step(logic [AW-1:0] a, logic h, logic lo_n, logic hi, string req);
      item_t it;
      logic [AW-1:0] eff;
      @(posedge clk);
      #1;
      addr = a; hold = h; en_lo_n = lo_n; en_hi = hi;
      eff = h ? model_store : a;
      it.exp = pattern(eff, lo_n, hi);
      it.req = req;
      sb.push_back(it);
      if (!h) model_store = a; // captured at the coming edge
      -> drv_ev;
      #2;
   endtask

   // monitor: pops and compares
   initial begin
      forever begin
         item_t it;
         @(drv_ev);
         #1;
         it = sb.pop_front();
         n_run++;
         if (sel_n !== it.exp) begin
            n_fail++;
            $display("FAIL %s: sel_n=%b expected %b", it.req, sel_n, it.exp);
         end
         n_run++; // R7 at most one low on every sample
         if ($countones(~sel_n) > 1) begin
            n_fail++;
            $display("FAIL R7: sel_n=%b expected at most one low", sel_n);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      model_store = '0;
      // R8: reset clears store, shows on Y0 when enabled with hold high
      step(3'd5, 1'b1, 1'b0, 1'b1, "R8");
      step(3'd5, 1'b1, 1'b1, 1'b0, "R8/R5");
      // R1: sweep open addresses
      for (int i = 0; i < NO; i++) step(AW'(i), 1'b0, 1'b0, 1'b1, "R1");
      // R2: capture then close
      step(3'd3, 1'b0, 1'b0, 1'b1, "R1");
      step(3'd6, 1'b1, 1'b0, 1'b1, "R2");
      // R3: toggle address while held
      step(3'd1, 1'b1, 1'b0, 1'b1, "R3");
      step(3'd7, 1'b1, 1'b0, 1'b1, "R3");
      step(3'd0, 1'b1, 1'b0, 1'b1, "R3");
      // R5 / R6: disable combos while held, then re-enable
      step(3'd2, 1'b1, 1'b1, 1'b1, "R5");
      step(3'd4, 1'b1, 1'b0, 1'b0, "R5");
      step(3'd5, 1'b1, 1'b1, 1'b0, "R5");
      step(3'd5, 1'b1, 1'b0, 1'b1, "R6");
      // R4: reopen passes live address at once
      step(3'd7, 1'b0, 1'b0, 1'b1, "R4");
      // R5: four enable combinations with the hold open
      step(3'd2, 1'b0, 1'b0, 1'b0, "R5");
      step(3'd2, 1'b0, 1'b0, 1'b1, "R5");
      step(3'd2, 1'b0, 1'b1, 1'b0, "R5");
      step(3'd2, 1'b0, 1'b1, 1'b1, "R5");
      // R2: second capture at another value, then hold
      step(3'd6, 1'b0, 1'b0, 1'b1, "R1");
      step(3'd1, 1'b1, 1'b0, 1'b1, "R2");
      step(3'd3, 1'b1, 1'b0, 1'b1, "R3");
      @(posedge clk);
      #4;
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule